// File: doc/BRIEF.md
# Multi-Dimensional Matrix Index Remapper

This block is an index sequencer. It takes a run length and a 32-bit shape word, and it turns the plain element count 0, 1, 2, ... into a reordered stream of 7-bit element indices. The shape word treats the vector as an array of up to three dimensions of any size from 1 to 64. It picks which dimension is the innermost, middle and outermost loop. Any dimension can be made to count downward. One dimension can be dropped from the address, which gives repeated or modulo patterns, and a small constant can be added to every index. Typical uses are transposed or outer-product element orders, driven from one hardware loop counter.

A single-cycle `start` pulse while the block is idle captures the shape word and the run length. From the next cycle on, indices are offered on a valid/ready stream. An index is consumed on any clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the offered index, `out_valid` and `out_last` do not change. After the last index is consumed, `out_valid` falls and the block is idle again.

Top module: `mdr_index_remapper`

## Requirements
- R1: After reset, `out_valid` and `out_last` are low.
- R2: When the block is idle, a `start` with `vec_len` > 0 captures `shape_word` and `vec_len`, and `out_valid` is high from the following cycle. Exactly `vec_len` indices are delivered. `out_last` is high on the final index only, and `out_valid` is low in the cycle after that index is taken.
- R3: A shape word that is all zero, or whose bits 31:30 are not 00, or whose bits 20:18 hold 6 or 7, gives the linear count as the index: 0, 1, 2, ...
- R4: Bits 5:0, 11:6 and 17:12 hold the x, y and z sizes minus one. The index is x + y·X + z·X·Y (mod 128), where X and Y are the x and y sizes.
- R5: Bits 20:18 choose the loop nesting, listed innermost first: 0 (x,y,z), 1 (x,z,y), 2 (y,x,z), 3 (y,z,x), 4 (z,x,y), 5 (z,y,x).
- R6: Bits 23:21 (bit 21 for x, 22 for y, 23 for z) make the matching dimension count from its size minus one down to 0.
- R7: Bits 29:28 drop one dimension from the index: 0 none, 1 x, 2 y, 3 z. A dropped dimension adds nothing, and the strides of the others are formed as if it did not exist.
- R8: The 4-bit value in bits 27:24 is added to every remapped index, modulo 128.
- R9: The run ends after `vec_len` indices, even if that is fewer than the array holds. If `vec_len` is larger than the array, the pattern starts again from the beginning.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_index` and `out_last` hold their values.
- R11: While a run is in progress, `start`, `shape_word` and `vec_len` have no effect.
- R12: A `start` with `vec_len` = 0 is ignored, and `out_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a run when the block is idle |
| shape_word | input | 32 | Array shape, loop order, inversion, skip and offset |
| vec_len | input | 7 | Number of indices in the run |
| out_ready | input | 1 | Consumer can take an index |
| out_valid | output | 1 | An index is offered |
| out_index | output | 7 | Remapped element index |
| out_last | output | 1 | Marks the final index of the run |

## Verification
The bench runs a table of shapes. Linear shapes show that the pass-through cases differ from matrix decoding. Plain 2D and 3D arrays check the stride products. Each loop order tells apart the nesting positions that a transpose would otherwise hide. Inverted axes check the count-down arithmetic. Each of the three skip codes checks the reduced strides, including the repeat and modulo patterns. Large offsets check the wrap at 128. Short and over-long runs separate ending the run early from wrapping the pattern. Every shape is also run with a stalling consumer. Directed cases cover the reset state, a zero-length start, a long hold, and a start pulse with new inputs in the middle of a run.

// File: rtl/mdr_pkg.sv
package mdr_pkg;
  localparam int unsigned NDIM  = 3;
  localparam int unsigned DIM_W = 6;
  localparam int unsigned IDX_W = 7;
  localparam int unsigned AX_W  = 2;

  // shape word field bases
  localparam int unsigned F_PERM = 18;
  localparam int unsigned F_INV  = 21;
  localparam int unsigned F_OFF  = 24;
  localparam int unsigned F_SKIP = 28;
  localparam int unsigned F_MODE = 30;
  localparam int unsigned OFF_W  = 4;

  typedef enum logic [1:0] {
    SKIP_NONE = 2'd0,
    SKIP_X    = 2'd1,
    SKIP_Y    = 2'd2,
    SKIP_Z    = 2'd3
  } skip_e;

  localparam logic [1:0] MODE_MATRIX = 2'b00;
endpackage

// File: rtl/mdr_shape_decode.sv
module mdr_shape_decode
  import mdr_pkg::*;
#(
  parameter int unsigned N  = NDIM,
  parameter int unsigned DW = DIM_W,
  parameter int unsigned IW = IDX_W,
  parameter int unsigned AW = AX_W
) (
  input  logic [31:0]               shape,
  output logic                      passthru,
  output logic [N-1:0][DW-1:0]      dim_lim,
  output logic [N-1:0][AW-1:0]      loop_axis,
  output logic [N-1:0]              inv,
  output logic [N-1:0][IW-1:0]      stride,
  output logic [OFF_W-1:0]          offset
);
  logic [2:0] perm;
  skip_e      skip;

  // size fields repeat per dimension
  for (genvar d = 0; d < N; d++) begin : g_field
    assign dim_lim[d] = shape[d*DW +: DW];
  end

  assign perm   = shape[F_PERM +: 3];
  assign skip   = skip_e'(shape[F_SKIP +: 2]);
  assign inv    = shape[F_INV +: N];
  assign offset = shape[F_OFF +: OFF_W];

  always_comb begin
    passthru = (shape == '0) || (shape[F_MODE +: 2] != MODE_MATRIX) || (perm > 3'd5);
  end

  // loop position 0 is innermost
  always_comb begin
    case (perm)
      3'd1:    loop_axis = {AW'(1), AW'(2), AW'(0)};
      3'd2:    loop_axis = {AW'(2), AW'(0), AW'(1)};
      3'd3:    loop_axis = {AW'(0), AW'(2), AW'(1)};
      3'd4:    loop_axis = {AW'(1), AW'(0), AW'(2)};
      3'd5:    loop_axis = {AW'(0), AW'(1), AW'(2)};
      default: loop_axis = {AW'(2), AW'(1), AW'(0)};
    endcase
  end

  // strides: running product of retained sizes, mod 2^IW
  always_comb begin
    logic [IW-1:0] acc;
    acc = IW'(1);
    for (int d = 0; d < N; d++) begin
      if (skip != SKIP_NONE && int'(skip) == d + 1) begin
        stride[d] = '0;
      end else begin
        stride[d] = acc;
        acc = IW'(acc * (IW'(dim_lim[d]) + IW'(1)));
      end
    end
  end
endmodule

// File: rtl/mdr_loop_nest.sv
module mdr_loop_nest
  import mdr_pkg::*;
#(
  parameter int unsigned N  = NDIM,
  parameter int unsigned DW = DIM_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 step,
  input  logic [N-1:0][DW-1:0] lim,
  output logic [N-1:0][DW-1:0] cnt
);
  logic [N:0]   carry;
  logic [N-1:0] wrap;

  assign carry[0] = step;

  for (genvar k = 0; k < N; k++) begin : g_lvl
    assign wrap[k]    = (cnt[k] == lim[k]);
    assign carry[k+1] = carry[k] & wrap[k];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt[k] <= '0;
      else if (clear)     cnt[k] <= '0;
      else if (carry[k])  cnt[k] <= wrap[k] ? '0 : cnt[k] + DW'(1);
    end
  end
endmodule

// File: rtl/mdr_index_calc.sv
module mdr_index_calc
  import mdr_pkg::*;
#(
  parameter int unsigned N  = NDIM,
  parameter int unsigned DW = DIM_W,
  parameter int unsigned IW = IDX_W,
  parameter int unsigned AW = AX_W
) (
  input  logic                  passthru,
  input  logic [IW-1:0]         lin,
  input  logic [N-1:0][DW-1:0]  cnt,
  input  logic [N-1:0][DW-1:0]  dim_lim,
  input  logic [N-1:0][AW-1:0]  loop_axis,
  input  logic [N-1:0]          inv,
  input  logic [N-1:0][IW-1:0]  stride,
  input  logic [OFF_W-1:0]      offset,
  output logic [IW-1:0]         index
);
  logic [N-1:0][IW-1:0] term;

  for (genvar k = 0; k < N; k++) begin : g_term
    logic [AW-1:0] ax;
    logic [DW-1:0] val;
    assign ax      = loop_axis[k];
    assign val     = inv[ax] ? (dim_lim[ax] - cnt[k]) : cnt[k];
    assign term[k] = IW'(IW'(val) * stride[ax]);
  end

  always_comb begin
    logic [IW-1:0] sum;
    sum = IW'(offset);
    for (int k = 0; k < N; k++) sum = sum + term[k];
    index = passthru ? lin : sum;
  end
endmodule

// File: rtl/mdr_index_remapper.sv
module mdr_index_remapper
  import mdr_pkg::*;
#(
  parameter int unsigned N  = NDIM,
  parameter int unsigned DW = DIM_W,
  parameter int unsigned IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   shape_word,
  input  logic [IW-1:0] vec_len,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [IW-1:0] out_index,
  output logic          out_last
);
  localparam int unsigned AW = AX_W;

  logic          busy_q;
  logic [31:0]   shape_q;
  logic [IW-1:0] len_q;
  logic [IW-1:0] lin_q;

  logic accept, fire, at_end;

  logic                 passthru;
  logic [N-1:0][DW-1:0] dim_lim;
  logic [N-1:0][AW-1:0] loop_axis;
  logic [N-1:0]         inv;
  logic [N-1:0][IW-1:0] stride;
  logic [OFF_W-1:0]     offset;
  logic [N-1:0][DW-1:0] loop_lim;
  logic [N-1:0][DW-1:0] cnt;

  assign accept = !busy_q && start && (vec_len != '0);
  assign fire   = busy_q && out_ready;
  assign at_end = (lin_q == len_q - IW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      shape_q <= '0;
      len_q   <= '0;
      lin_q   <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      shape_q <= shape_word;
      len_q   <= vec_len;
      lin_q   <= '0;
    end else if (fire) begin
      if (at_end) busy_q <= 1'b0;
      else        lin_q  <= lin_q + IW'(1);
    end
  end

  mdr_shape_decode #(.N(N), .DW(DW), .IW(IW), .AW(AW)) u_dec (
    .shape     (shape_q),
    .passthru  (passthru),
    .dim_lim   (dim_lim),
    .loop_axis (loop_axis),
    .inv       (inv),
    .stride    (stride),
    .offset    (offset)
  );

  for (genvar k = 0; k < N; k++) begin : g_lim
    assign loop_lim[k] = dim_lim[loop_axis[k]];
  end

  mdr_loop_nest #(.N(N), .DW(DW)) u_nest (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .step  (fire && !at_end),
    .lim   (loop_lim),
    .cnt   (cnt)
  );

  mdr_index_calc #(.N(N), .DW(DW), .IW(IW), .AW(AW)) u_calc (
    .passthru  (passthru),
    .lin       (lin_q),
    .cnt       (cnt),
    .dim_lim   (dim_lim),
    .loop_axis (loop_axis),
    .inv       (inv),
    .stride    (stride),
    .offset    (offset),
    .index     (out_index)
  );

  assign out_valid = busy_q;
  assign out_last  = busy_q && at_end;
endmodule

// File: rtl/mdr_remap_checker.sv
module mdr_remap_checker #(
  parameter int unsigned IW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [IW-1:0] vec_len,
  input logic          out_ready,
  input logic          out_valid,
  input logic [IW-1:0] out_index,
  input logic          out_last
);
  assert_last_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_start_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && start && vec_len != '0) |=> out_valid);

  assert_end_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);

  assert_run_continues_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid);

  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_index) && $stable(out_last)));

  assert_zero_len_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && start && vec_len == '0) |=> !out_valid);
endmodule

bind mdr_index_remapper mdr_remap_checker #(.IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .vec_len   (vec_len),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_index (out_index),
  .out_last  (out_last)
);

// File: tb/mdr_index_remapper_test.sv
module mdr_index_remapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] shape_word = '0;
  logic [6:0]  vec_len = '0;
  logic        out_ready = 1'b0;
  logic        out_valid;
  logic [6:0]  out_index;
  logic        out_last;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mdr_index_remapper uut (
    .clk(clk), .rst_n(rst_n), .start(start), .shape_word(shape_word),
    .vec_len(vec_len), .out_ready(out_ready), .out_valid(out_valid),
    .out_index(out_index), .out_last(out_last)
  );

  function automatic logic [31:0] shp(int md, int sk, int of, int iv, int pm,
                                      int z, int y, int x);
    return {md[1:0], sk[1:0], of[3:0], iv[2:0], pm[2:0], z[5:0], y[5:0], x[5:0]};
  endfunction

  localparam int NCASE = 17;
  localparam logic [38:0] TBL [NCASE] = '{
    {shp(0,0,0,0,0,0,0,0),  7'd10},  // R3 all zero
    {shp(2,0,0,0,0,0,0,3),  7'd8},   // R3 other mode
    {shp(0,0,0,0,6,0,0,2),  7'd8},   // R3 permute 6
    {shp(0,0,0,0,0,0,3,2),  7'd12},  // R4 2D
    {shp(0,0,0,0,0,1,1,2),  7'd12},  // R4 3D
    {shp(0,0,0,0,2,0,3,2),  7'd12},  // R5 y innermost
    {shp(0,0,0,0,5,1,2,1),  7'd12},  // R5 z,y,x
    {shp(0,0,0,0,3,2,1,1),  7'd12},  // R5 y,z,x
    {shp(0,0,0,1,0,0,1,3),  7'd8},   // R6 x down
    {shp(0,0,0,6,0,1,2,1),  7'd12},  // R6 y,z down
    {shp(0,1,0,0,0,0,2,2),  7'd9},   // R7 skip x: repeat
    {shp(0,3,0,0,0,2,0,2),  7'd9},   // R7 skip z: modulo
    {shp(0,2,0,0,4,1,2,1),  7'd12},  // R7 skip y
    {shp(0,0,5,0,0,0,2,3),  7'd12},  // R8 offset
    {shp(0,0,15,0,0,0,1,63),7'd127}, // R8 wrap at 128
    {shp(0,0,0,0,0,0,4,4),  7'd7},   // R9 short run
    {shp(0,0,0,0,0,0,0,2),  7'd10}   // R9 pattern restarts
  };
  string tags [NCASE] = '{"R3","R3","R3","R4","R4","R5","R5","R5","R6","R6",
                          "R7","R7","R7","R8","R8","R9","R9"};

  // independent model of the required index
  function automatic logic [6:0] exp_idx(logic [31:0] s, int i);
    int sz[3]; int ord[3]; int c[3]; int v[3]; int st[3]; int sum;
    if (s == 0 || s[31:30] != 0 || s[20:18] > 5) return i[6:0];
    sz[0] = int'(s[5:0]) + 1; sz[1] = int'(s[11:6]) + 1; sz[2] = int'(s[17:12]) + 1;
    case (s[20:18])
      3'd0: ord = '{0,1,2};
      3'd1: ord = '{0,2,1};
      3'd2: ord = '{1,0,2};
      3'd3: ord = '{1,2,0};
      3'd4: ord = '{2,0,1};
      default: ord = '{2,1,0};
    endcase
    c[0] = i % sz[ord[0]];
    c[1] = (i / sz[ord[0]]) % sz[ord[1]];
    c[2] = (i / (sz[ord[0]] * sz[ord[1]])) % sz[ord[2]];
    for (int k = 0; k < 3; k++) v[ord[k]] = c[k];
    for (int d = 0; d < 3; d++) if (s[21+d]) v[d] = sz[d] - 1 - v[d];
    case (s[29:28])
      2'd0: st = '{1, sz[0], sz[0]*sz[1]};
      2'd1: st = '{0, 1, sz[1]};
      2'd2: st = '{1, 0, sz[0]};
      default: st = '{1, sz[0], 0};
    endcase
    sum = v[0]*st[0] + v[1]*st[1] + v[2]*st[2] + int'(s[27:24]);
    return 7'(sum % 128);
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic run_case(logic [31:0] s, logic [6:0] vl, bit stall, bit poke, string tag);
    int k = 0;
    int cyc = 0;
    @(negedge clk);
    shape_word = s; vec_len = vl; start = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    shape_word = ~s; vec_len = 7'd1;   // R11: captured values must be kept
    chk(out_valid === 1'b1, "R2 valid after start", int'(out_valid), 1);
    while (k < int'(vl) && cyc < 3000) begin
      out_ready = stall ? (cyc % 3 != 2) : 1'b1;
      if (poke && k == 2) begin
        start = 1'b1; shape_word = shp(0,0,3,0,0,0,0,5); vec_len = 7'd2;
      end else begin
        start = 1'b0;
      end
      if (out_valid && out_ready) begin
        chk(out_index === exp_idx(s, k), tag, int'(out_index), int'(exp_idx(s, k)));
        chk(out_last === (k == int'(vl) - 1), "R2 last flag", int'(out_last),
            int'(k == int'(vl) - 1));
        k++;
      end else if (!out_valid) begin
        chk(1'b0, "R2 valid dropped early", 0, 1);
        k = int'(vl);
      end
      cyc++;
      @(negedge clk);
    end
    start = 1'b0; out_ready = 1'b0;
    chk(out_valid === 1'b0, "R2 idle after run", int'(out_valid), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [6:0] held;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0 && out_last === 1'b0, "R1 reset state",
        int'({out_valid, out_last}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1 idle after reset", int'(out_valid), 0);

    for (int e = 0; e < NCASE; e++)
      run_case(TBL[e][38:7], TBL[e][6:0], e[0], 1'b0, tags[e]);

    // R12: zero length start
    @(negedge clk);
    shape_word = shp(0,0,0,0,0,0,1,1); vec_len = 7'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) begin
      chk(out_valid === 1'b0, "R12 zero length ignored", int'(out_valid), 0);
      @(negedge clk);
    end

    // R10: long stall holds the offered index
    shape_word = shp(0,0,0,1,0,0,0,3); vec_len = 7'd4; start = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    held = out_index;
    chk(held === 7'd3, "R10 first index", int'(held), 3);
    repeat (4) begin
      @(negedge clk);
      chk(out_valid === 1'b1 && out_index === held, "R10 hold under stall",
          int'(out_index), int'(held));
    end
    out_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      chk(out_index === 7'(3 - k), "R10 drain after stall", int'(out_index), 3 - k);
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(out_valid === 1'b0, "R10 idle after drain", int'(out_valid), 0);

    // R11: start pulse mid-run is ignored
    run_case(shp(0,0,0,0,2,0,2,1), 7'd6, 1'b1, 1'b1, "R11");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule